// File: doc/BRIEF.md
# Synthesizer PLL Bring-Up Sequencer

This block is a hardware state machine that takes a direct digital synthesizer from reset to a locked PLL without help from software. A one-cycle start pulse launches a fixed sequence. The sequencer issues register writes and one register read through a request/response port, and it pulses an update strobe after each configuration write. It then polls its own channel's bit of a shared lock-status vector. Register transport (the serial link itself) sits behind the request port and is outside this block.

The PLL multiplier, charge-pump current and VCO band arrive as configuration inputs. They are captured at start and packed into the PLL configuration word. A blind mode skips the identity readback and the lock polling and waits a fixed time instead. On completion the block raises exactly one of three results: done, identity mismatch or lock timeout. That result stays until the next start. All waits are counted in clock cycles, derived from a clock-frequency parameter.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset the block is idle: busy, done, err_ident, err_lock, io_update and req_valid are all low.
- R2: A start pulse while idle launches the sequence and captures blind, pll_n, pll_cp and pll_vco. A start pulse while busy has no effect, and neither do configuration changes made while busy.
- R3: The first request writes 0x00000002 to address 0x00. It is followed by an io_update pulse of ceil(CLK_HZ/1e6) cycles and then a settle wait of SETTLE_MS milliseconds (ceil(CLK_HZ/1000) cycles each).
- R4: In normal mode the next request is a read of address 0x03. If the low 8 bits of the response differ from 0x7F, err_ident is raised, the sequence stops and no further request or strobe is issued. The upper 24 response bits are ignored.
- R5: Three writes follow, each followed by one io_update pulse: 0x01400020 to address 0x01, then W|0x400 to address 0x02, then W to address 0x02. W = 0x0807C100 | vco<<24 | cp<<19 | n<<1.
- R6: In normal mode the lock bit CH_IDX of lock_sts is sampled once per poll, and polls are 1 + POLL_GAP_MS·ms cycles apart. After the first sample that is high, done rises at the end of that poll's gap. The other lock_sts bits are ignored.
- R7: If POLL_LIMIT samples are all low, err_lock is raised at the end of the last gap, POLL_LIMIT·(1 + gap) cycles after the last strobe.
- R8: In blind mode no read is issued, lock_sts is ignored, and done rises BLIND_MS·ms cycles after the last strobe.
- R9: At most one of done, err_ident and err_lock is high. They hold while idle, and a start that launches the sequence clears them.
- R10: While req_valid is high and req_ready is low, req_valid, req_read, req_addr and req_data hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| blind | input | 1 | Skip readback and polling, use fixed wait |
| pll_n | input | 7 | PLL multiplier (12..127) |
| pll_cp | input | 3 | Charge-pump setting (0..7) |
| pll_vco | input | 3 | VCO band (0..5) |
| req_valid | output | 1 | Register request pending |
| req_ready | input | 1 | Request accepted this cycle |
| req_read | output | 1 | Request is a read |
| req_addr | output | 8 | Register address |
| req_data | output | 32 | Write data (zero for reads) |
| rsp_valid | input | 1 | Read response present |
| rsp_data | input | 32 | Read response data |
| lock_sts | input | NUM_CH | Per-channel PLL lock flags |
| io_update | output | 1 | Update strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed successfully |
| err_ident | output | 1 | Identity readback mismatch |
| err_lock | output | 1 | Lock not seen within the poll limit |

## Verification
A wrong state would show up at the ports in two ways. The order of requests would change, with an address, data word or read flag out of place, from the first request on. The strobe count or a pulse width would also be wrong. Timer or poll-counter faults move the instant that busy falls. Because the bench holds lock high from a chosen poll onward, a counter that is off by one shifts completion by a whole poll period or flips the result between done and err_lock. Capture faults show up when configuration changes mid-run alter the PLL word or the mode.

// File: rtl/pll_bringup_pkg.sv
package pll_bringup_pkg;

  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] ADDR_MODE = 8'h00;
  localparam logic [REG_AW-1:0] ADDR_CLK  = 8'h01;
  localparam logic [REG_AW-1:0] ADDR_PLL  = 8'h02;
  localparam logic [REG_AW-1:0] ADDR_ID   = 8'h03;

  localparam logic [REG_DW-1:0] MODE_WORD = 32'h0000_0002;
  localparam logic [REG_DW-1:0] CLK_WORD  = 32'h0140_0020;
  localparam logic [REG_DW-1:0] PLL_BASE  = 32'h0807_C100;
  localparam logic [REG_DW-1:0] PFD_RST   = 32'h0000_0400;
  localparam logic [REG_DW-1:0] ID_MASK   = 32'h0000_00FF;
  localparam logic [REG_DW-1:0] ID_VALUE  = 32'h0000_007F;

  typedef enum logic [3:0] {
    S_IDLE, S_WR_MODE, S_UPD_MODE, S_SETTLE, S_RD_ID, S_RD_RSP,
    S_WR_CLK, S_UPD_CLK, S_WR_PFD, S_UPD_PFD, S_WR_PLL, S_UPD_PLL,
    S_BLIND, S_POLL, S_POLL_GAP
  } seq_state_e;

  // Cycles covering one unit of time, rounded up, never zero.
  function automatic int unsigned cyc_ceil(longint unsigned hz, longint unsigned per_s);
    longint unsigned q;
    q = (hz + per_s - 1) / per_s;
    return (q == 0) ? 1 : int'(q);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // PLL configuration word; pfd selects the detector-reset variant.
  function automatic logic [REG_DW-1:0] pll_word(logic [2:0] vco, logic [2:0] cp,
                                                 logic [6:0] n, logic pfd);
    logic [REG_DW-1:0] w;
    w = PLL_BASE | (REG_DW'(vco) << 24) | (REG_DW'(cp) << 19) | (REG_DW'(n) << 1);
    return pfd ? (w | PFD_RST) : w;
  endfunction

endpackage

// File: rtl/pll_bringup_timer.sv
module pll_bringup_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  // A load of L keeps expired low for L-1 cycles, so the caller stays L cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val - W'(1);
    else if (cnt != '0)      cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pll_bringup_pollctr.sv
module pll_bringup_pollctr #(
  parameter int unsigned LIMIT = 100,
  parameter int unsigned W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);
  logic [W-1:0] misses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      misses <= '0;
    else if (clear)  misses <= '0;
    else if (step)   misses <= misses + W'(1);
  end

  assign last = (misses == W'(LIMIT - 1));
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned CH_IDX      = 0,
  parameter int unsigned POLL_LIMIT  = 100,
  parameter int unsigned SETTLE_MS   = 1,
  parameter int unsigned POLL_GAP_MS = 1,
  parameter int unsigned BLIND_MS    = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              blind,
  input  logic [6:0]        pll_n,
  input  logic [2:0]        pll_cp,
  input  logic [2:0]        pll_vco,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_read,
  output logic [7:0]        req_addr,
  output logic [31:0]       req_data,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  input  logic [NUM_CH-1:0] lock_sts,
  output logic              io_update,
  output logic              busy,
  output logic              done,
  output logic              err_ident,
  output logic              err_lock
);
  import pll_bringup_pkg::*;

  localparam int unsigned US_CYC     = cyc_ceil(CLK_HZ, 1_000_000);
  localparam int unsigned MS_CYC     = cyc_ceil(CLK_HZ, 1_000);
  localparam int unsigned SETTLE_CYC = max2(SETTLE_MS * MS_CYC, 1);
  localparam int unsigned GAP_CYC    = max2(POLL_GAP_MS * MS_CYC, 1);
  localparam int unsigned BLIND_CYC  = max2(BLIND_MS * MS_CYC, 1);
  localparam int unsigned MAX_CYC    = max2(max2(US_CYC, SETTLE_CYC), max2(GAP_CYC, BLIND_CYC));
  localparam int unsigned TW         = $clog2(MAX_CYC + 1);
  localparam logic [NUM_CH-1:0] OWN_MASK = NUM_CH'(1) << CH_IDX;

  seq_state_e st, nxt;

  logic       blind_q;
  logic [6:0] n_q;
  logic [2:0] cp_q, vco_q;
  logic       lock_seen;

  // Named internal events
  logic          launch, req_fire, id_ok, own_lock, tmr_done, poll_last;
  logic          tmr_load, poll_clr, poll_step;
  logic [TW-1:0] tmr_val;
  logic          set_done, set_eid, set_elock;

  assign launch   = (st == S_IDLE) && start;
  assign req_fire = req_valid && req_ready;
  assign id_ok    = ((rsp_data & ID_MASK) == ID_VALUE);
  assign own_lock = |(lock_sts & OWN_MASK);

  pll_bringup_timer #(.W(TW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  pll_bringup_pollctr #(.LIMIT(POLL_LIMIT)) poll_i (
    .clk(clk), .rst_n(rst_n), .clear(poll_clr), .step(poll_step), .last(poll_last)
  );

  always_comb begin
    nxt       = st;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    poll_clr  = 1'b0;
    poll_step = 1'b0;
    set_done  = 1'b0;
    set_eid   = 1'b0;
    set_elock = 1'b0;
    case (st)
      S_IDLE:     if (start) nxt = S_WR_MODE;
      S_WR_MODE:  if (req_ready) begin nxt = S_UPD_MODE; tmr_load = 1'b1; tmr_val = TW'(US_CYC); end
      S_UPD_MODE: if (tmr_done) begin nxt = S_SETTLE; tmr_load = 1'b1; tmr_val = TW'(SETTLE_CYC); end
      S_SETTLE:   if (tmr_done) nxt = blind_q ? S_WR_CLK : S_RD_ID;
      S_RD_ID:    if (req_ready) nxt = S_RD_RSP;
      S_RD_RSP:   if (rsp_valid) begin
                    if (id_ok) nxt = S_WR_CLK;
                    else begin nxt = S_IDLE; set_eid = 1'b1; end
                  end
      S_WR_CLK:   if (req_ready) begin nxt = S_UPD_CLK; tmr_load = 1'b1; tmr_val = TW'(US_CYC); end
      S_UPD_CLK:  if (tmr_done) nxt = S_WR_PFD;
      S_WR_PFD:   if (req_ready) begin nxt = S_UPD_PFD; tmr_load = 1'b1; tmr_val = TW'(US_CYC); end
      S_UPD_PFD:  if (tmr_done) nxt = S_WR_PLL;
      S_WR_PLL:   if (req_ready) begin nxt = S_UPD_PLL; tmr_load = 1'b1; tmr_val = TW'(US_CYC); end
      S_UPD_PLL:  if (tmr_done) begin
                    poll_clr = 1'b1;
                    if (blind_q) begin nxt = S_BLIND; tmr_load = 1'b1; tmr_val = TW'(BLIND_CYC); end
                    else nxt = S_POLL;
                  end
      S_BLIND:    if (tmr_done) begin nxt = S_IDLE; set_done = 1'b1; end
      S_POLL:     begin nxt = S_POLL_GAP; tmr_load = 1'b1; tmr_val = TW'(GAP_CYC); end
      S_POLL_GAP: if (tmr_done) begin
                    if (lock_seen)      begin nxt = S_IDLE; set_done  = 1'b1; end
                    else if (poll_last) begin nxt = S_IDLE; set_elock = 1'b1; end
                    else                begin nxt = S_POLL; poll_step = 1'b1; end
                  end
      default:    nxt = S_IDLE;
    endcase
  end

  always_comb begin
    req_valid = 1'b0;
    req_read  = 1'b0;
    req_addr  = '0;
    req_data  = '0;
    case (st)
      S_WR_MODE: begin req_valid = 1'b1; req_addr = ADDR_MODE; req_data = MODE_WORD; end
      S_RD_ID:   begin req_valid = 1'b1; req_read = 1'b1; req_addr = ADDR_ID; end
      S_WR_CLK:  begin req_valid = 1'b1; req_addr = ADDR_CLK; req_data = CLK_WORD; end
      S_WR_PFD:  begin req_valid = 1'b1; req_addr = ADDR_PLL; req_data = pll_word(vco_q, cp_q, n_q, 1'b1); end
      S_WR_PLL:  begin req_valid = 1'b1; req_addr = ADDR_PLL; req_data = pll_word(vco_q, cp_q, n_q, 1'b0); end
      default:   ;
    endcase
  end

  assign io_update = (st == S_UPD_MODE) || (st == S_UPD_CLK) ||
                     (st == S_UPD_PFD)  || (st == S_UPD_PLL);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      blind_q   <= 1'b0;
      n_q       <= '0;
      cp_q      <= '0;
      vco_q     <= '0;
      lock_seen <= 1'b0;
      done      <= 1'b0;
      err_ident <= 1'b0;
      err_lock  <= 1'b0;
    end else begin
      st <= nxt;
      if (launch) begin
        blind_q   <= blind;
        n_q       <= pll_n;
        cp_q      <= pll_cp;
        vco_q     <= pll_vco;
        lock_seen <= 1'b0;
        done      <= 1'b0;
        err_ident <= 1'b0;
        err_lock  <= 1'b0;
      end
      if (st == S_POLL) lock_seen <= own_lock;
      if (set_done)  done      <= 1'b1;
      if (set_eid)   err_ident <= 1'b1;
      if (set_elock) err_lock  <= 1'b1;
    end
  end

  logic unused_fire;
  assign unused_fire = req_fire;
endmodule

// File: rtl/pll_bringup_chk.sv
module pll_bringup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err_ident,
  input logic        err_lock,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_read,
  input logic [7:0]  req_addr,
  input logic [31:0] req_data,
  input logic        io_update,
  input logic        blind_q,
  input logic        lock_seen,
  input logic        poll_last
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !io_update);

  a_r2_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done && !err_ident && !err_lock);

  a_r4_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_read |-> req_addr == 8'h03);

  a_r6_done_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && !blind_q |-> $past(lock_seen));

  a_r7_timeout_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_lock) |-> $past(poll_last));

  a_r8_blind_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    busy && blind_q |-> !(req_valid && req_read));

  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_ident, err_lock}));

  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(done) && $stable(err_ident) && $stable(err_lock));

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_read) && $stable(req_addr) && $stable(req_data));
endmodule

bind pll_bringup_seq pll_bringup_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_ident(err_ident), .err_lock(err_lock), .req_valid(req_valid),
  .req_ready(req_ready), .req_read(req_read), .req_addr(req_addr),
  .req_data(req_data), .io_update(io_update), .blind_q(blind_q),
  .lock_seen(lock_seen), .poll_last(poll_last)
);

// File: tb/pll_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module pll_bringup_seq_tb_top;
  localparam int unsigned CLK_HZ = 40_000;
  localparam int unsigned NCH    = 4;
  localparam int unsigned CH     = 2;
  localparam int LIMIT = 100;
  localparam int MS    = (CLK_HZ + 999) / 1000;
  localparam int US    = (CLK_HZ + 999_999) / 1_000_000;
  localparam int PERIOD = MS + 1;

  // Vector table: mode, PLL settings, read response, first locked poll, expected result (0 done, 1 ident, 2 lock)
  localparam int NV = 7;
  localparam bit          V_BLIND [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [6:0]  V_N     [NV] = '{7'd40, 7'd12, 7'd127, 7'd100, 7'd25, 7'd64, 7'd90};
  localparam logic [2:0]  V_CP    [NV] = '{3'd7, 3'd0, 3'd3, 3'd5, 3'd2, 3'd1, 3'd6};
  localparam logic [2:0]  V_VCO   [NV] = '{3'd5, 3'd0, 3'd2, 3'd4, 3'd1, 3'd3, 3'd5};
  localparam logic [31:0] V_RSP   [NV] = '{32'h0000_007F, 32'hFFFF_FF7F, 32'h0000_007E,
                                           32'h0000_007F, 32'h0000_0000, 32'h1234_567F, 32'h0000_007F};
  localparam int          V_LOCK  [NV] = '{1, 37, 1, 0, 0, 100, 3};
  localparam int          V_OUT   [NV] = '{0, 0, 1, 2, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, blind = 1'b0;
  logic [6:0] pll_n = '0;
  logic [2:0] pll_cp = '0, pll_vco = '0;
  logic req_valid, req_read, io_update, busy, done, err_ident, err_lock;
  logic req_ready = 1'b1;
  logic [7:0] req_addr;
  logic [31:0] req_data;
  logic rsp_valid = 1'b0;
  logic [31:0] rsp_data = 32'hDEAD_BEEF;
  logic own_lock = 1'b0;
  logic [NCH-1:0] lock_sts;

  assign lock_sts = {1'b1, own_lock, 2'b11};

  always #2.5 clk = ~clk;

  pll_bringup_seq #(.CLK_HZ(CLK_HZ), .NUM_CH(NCH), .CH_IDX(CH), .POLL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blind(blind), .pll_n(pll_n),
    .pll_cp(pll_cp), .pll_vco(pll_vco), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .lock_sts(lock_sts), .io_update(io_update), .busy(busy),
    .done(done), .err_ident(err_ident), .err_lock(err_lock)
  );

  int errs = 0, checks = 0;
  int nlog, npulse, tail, tick;
  logic        lg_rd   [16];
  logic [7:0]  lg_addr [16];
  logic [31:0] lg_dat  [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pllw(logic [2:0] vco, logic [2:0] cp, logic [6:0] n);
    return 32'h0807_C100 + (32'(vco) * 32'h0100_0000) + (32'(cp) * 32'h0008_0000) + (32'(n) * 2);
  endfunction

  task automatic run_case(input bit bl, input logic [6:0] n, input logic [2:0] cp,
                          input logic [2:0] vco, input logic [31:0] rsp,
                          input int lockpoll, input int inject_at);
    int run, rsp_cnt, guard;
    blind = bl; pll_n = n; pll_cp = cp; pll_vco = vco;
    nlog = 0; npulse = 0; tail = 0; run = 0; rsp_cnt = 0; guard = 0;
    own_lock = 1'b0; rsp_valid = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !done && !err_ident && !err_lock, "R2", "launch clears results",
        {busy, done, err_ident, err_lock}, 4'b1000);
    while (busy && guard < 20000) begin
      req_ready = (tick % 3) != 2;
      rsp_valid = 1'b0;
      rsp_data  = 32'hDEAD_BEEF;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin rsp_valid = 1'b1; rsp_data = rsp; end
      end
      if (req_valid && req_ready) begin
        if (nlog < 16) begin
          lg_rd[nlog] = req_read; lg_addr[nlog] = req_addr; lg_dat[nlog] = req_data;
        end
        nlog++;
        if (req_read) rsp_cnt = 2;
      end
      if (io_update) run++;
      else if (run > 0) begin
        chk(run == US, "R3", "strobe width", run, US);
        npulse++;
        run = 0;
      end
      if (busy && !io_update && npulse == 4) tail++;
      own_lock = (lockpoll > 0) && (tail >= (lockpoll - 1) * PERIOD + 1);
      if (inject_at > 0 && tail == inject_at) begin
        start = 1'b1; blind = ~bl; pll_n = 7'h55; pll_cp = 3'h0; pll_vco = 3'h7;
      end else start = 1'b0;
      tick++; guard++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(guard < 20000, "R9", "sequence ends", guard, 20000);
  endtask

  task automatic check_case(input bit bl, input logic [6:0] n, input logic [2:0] cp,
                            input logic [2:0] vco, input int out, input int lockpoll);
    logic        e_rd   [8];
    logic [7:0]  e_addr [8];
    logic [31:0] e_dat  [8];
    int ne, exp_tail;
    ne = 0;
    e_rd[ne] = 0; e_addr[ne] = 8'h00; e_dat[ne] = 32'h2; ne++;
    if (!bl) begin e_rd[ne] = 1; e_addr[ne] = 8'h03; e_dat[ne] = 32'h0; ne++; end
    if (out != 1) begin
      e_rd[ne] = 0; e_addr[ne] = 8'h01; e_dat[ne] = 32'h0140_0020; ne++;
      e_rd[ne] = 0; e_addr[ne] = 8'h02; e_dat[ne] = pllw(vco, cp, n) | 32'h400; ne++;
      e_rd[ne] = 0; e_addr[ne] = 8'h02; e_dat[ne] = pllw(vco, cp, n); ne++;
    end
    chk(nlog == ne, bl ? "R8" : "R4", "request count", nlog, ne);
    for (int i = 0; i < ne && i < nlog; i++) begin
      chk(lg_rd[i] == e_rd[i] && lg_addr[i] == e_addr[i],
          (i == 0) ? "R3" : (e_rd[i] ? "R4" : "R5"), "request kind/address",
          {lg_rd[i], lg_addr[i]}, {e_rd[i], e_addr[i]});
      chk(lg_dat[i] == e_dat[i], (i == 0) ? "R3" : "R5", "request data", lg_dat[i], e_dat[i]);
    end
    chk(npulse == ((out == 1) ? 1 : 4), "R5", "strobe count", npulse, (out == 1) ? 1 : 4);
    if (out == 1) begin
      chk(err_ident && !done && !err_lock, "R4", "identity error result",
          {done, err_ident, err_lock}, 3'b010);
    end else if (out == 2) begin
      chk(err_lock && !done && !err_ident, "R7", "lock timeout result",
          {done, err_ident, err_lock}, 3'b001);
      chk(tail == LIMIT * PERIOD, "R7", "timeout instant", tail, LIMIT * PERIOD);
    end else begin
      chk(done && !err_ident && !err_lock, bl ? "R8" : "R6", "done result",
          {done, err_ident, err_lock}, 3'b100);
      exp_tail = bl ? 100 * MS : lockpoll * PERIOD;
      chk(tail == exp_tail, bl ? "R8" : "R6", "completion instant", tail, exp_tail);
    end
  endtask

  initial begin
    tick = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !err_ident && !err_lock && !io_update && !req_valid, "R1",
        "reset outputs", {busy, done, err_ident, err_lock, io_update, req_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !req_valid && !io_update, "R1", "idle after reset",
        {busy, req_valid, io_update}, 0);

    for (int v = 0; v < NV; v++) begin
      run_case(V_BLIND[v], V_N[v], V_CP[v], V_VCO[v], V_RSP[v], V_LOCK[v], 0);
      check_case(V_BLIND[v], V_N[v], V_CP[v], V_VCO[v], V_OUT[v], V_LOCK[v]);
    end

    // R9: result holds while idle
    repeat (12) @(negedge clk);
    chk(done && !err_ident && !err_lock && !busy, "R9", "done holds while idle",
        {done, err_ident, err_lock, busy}, 4'b1000);

    // R2: start and configuration changes during a blind run have no effect
    run_case(1'b1, 7'd33, 3'd4, 3'd2, 32'h0, 0, 50);
    check_case(1'b1, 7'd33, 3'd4, 3'd2, 0, 0);

    // R2/R9: a start while idle after an identity error clears it
    run_case(1'b0, 7'd50, 3'd1, 3'd1, 32'h0000_00FF, 0, 0);
    check_case(1'b0, 7'd50, 3'd1, 3'd1, 1, 0);
    repeat (5) @(negedge clk);
    chk(err_ident && !busy, "R9", "error holds while idle", {err_ident, busy}, 2'b10);
    run_case(1'b0, 7'd20, 3'd2, 3'd3, 32'h0000_007F, 2, 0);
    check_case(1'b0, 7'd20, 3'd2, 3'd3, 0, 2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule